// File: doc/BRIEF.md
# Run-Length Context Merge Stage

This stage sits between the per-sample context generators of a bit-plane coder and the arithmetic coder. Samples of one stripe column (four rows) arrive one per valid cycle, row 0 first. Each sample carries a magnitude pair (context label and decision bit), an optional sign pair, the coding pass it belongs to, and a run-length eligibility flag. The stage holds each sample until the rest of its column has been seen. Only then does it know whether the cleanup pass codes the column as a run. It then emits the final labelled decisions for that sample.

Because the three coding passes of a bit-plane are interleaved in one scan, every emitted pair carries a two-bit pass tag. Pass codes are 1 for significance propagation, 2 for refinement and 3 for cleanup. A single cycle can deliver zero to four pairs. They are packed from slot 0 upward in coding order, with a count. Context labels are computed upstream, and the arithmetic coder downstream consumes the slots.

Top module: `rlm_merge`

## Requirements
- R1: While reset is asserted and after its release until a sample is emitted, `out_cnt` is 0 and every output slot field is 0.
- R2: A sample's pairs appear at the clock edge that captures the third valid sample after it. This is three cycles later under back-to-back input. Idle cycles hold the column. An edge with `in_valid` low yields `out_cnt` 0, and `out_cnt` never exceeds 4.
- R3: Outside a run column, a sample emits its magnitude pair if `in_mag_vld` is set. It then emits its sign pair if `in_sgn_vld` is set. Both carry the sample's pass tag, and the decision is the supplied bit.
- R4: A column is a run column when `in_rl_elig` is 1 on its row 0. If all four magnitude bits are 0, row 0 emits one pair (pass 3, context 17, decision 0), and rows 1 to 3 emit nothing.
- R5: In a run column with a non-zero bit, let p be the lowest row whose magnitude bit is 1. Row 0 emits four pairs, all tagged pass 3. Slot 0 is context 17 with decision 1. Slot 1 is context 18 with p bit 1. Slot 2 is context 18 with p bit 0. Slot 3 holds the sign context and sign bit that were presented with row p.
- R6: In such a failed run column, rows 1 to p emit nothing whatever their valid bits. Rows after p are coded as in R3.
- R7: Output slots at index `out_cnt` and above read all zero.
- R8: `in_rl_elig` is ignored on rows 1 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A sample is presented this cycle |
| in_row | input | 2 | Row of the sample within its stripe column |
| in_rl_elig | input | 1 | Column qualifies for run-length coding (row 0 only) |
| in_pass | input | 2 | Coding pass of the sample (1, 2, 3) |
| in_mag_vld | input | 1 | Magnitude pair present |
| in_mag_ctx | input | 5 | Magnitude pair context label |
| in_mag_bit | input | 1 | Magnitude bit of this plane |
| in_sgn_vld | input | 1 | Sign pair present |
| in_sgn_ctx | input | 5 | Sign pair context label |
| in_sgn_bit | input | 1 | Sign decision |
| out_cnt | output | 3 | Number of valid slots this cycle |
| out_pass | output | 8 | Pass tags, slot k at bits [2k+1:2k] |
| out_ctx | output | 20 | Context labels, slot k at bits [5k+4:5k] |
| out_dec | output | 4 | Decisions, slot k at bit k |

## Verification
A corrupted column state would show within the same column. Rows after the interrupting sample would vanish, or suppressed rows would leak pairs, at the very next emission edges. A slip in the three-sample hold shifts every later group by one edge, so it breaks the first comparison that follows. A wrong run position shows in the uniform bits or the sign slot of the row-0 group. The bench compares every cycle's full slot bundle in order, so each of these appears at the first affected edge.

// File: rtl/rlm_pkg.sv
`timescale 1ns/1ps
package rlm_pkg;
  localparam int ROWS    = 4;
  localparam int ROW_W   = $clog2(ROWS);
  localparam int CTX_W   = 5;
  localparam int PASS_W  = 2;
  localparam int SLOTS   = ROW_W + 2;
  localparam int CNT_W   = $clog2(SLOTS + 1);
  localparam int HOLD    = ROWS - 1;
  localparam logic [PASS_W-1:0] PASS_CLEAN = 2'd3;

  typedef struct packed {
    logic [ROW_W-1:0]  row;
    logic              rl_elig;
    logic              m_vld;
    logic [CTX_W-1:0]  m_ctx;
    logic              m_bit;
    logic [PASS_W-1:0] pass;
    logic              s_vld;
    logic [CTX_W-1:0]  s_ctx;
    logic              s_bit;
  } smp_t;

  typedef struct packed {
    logic [PASS_W-1:0] pass;
    logic [CTX_W-1:0]  ctx;
    logic              dec;
  } pair_t;

  typedef enum logic [1:0] {
    EMIT_NONE,
    EMIT_PLAIN,
    EMIT_RUN_OK,
    EMIT_RUN_FAIL
  } emit_e;
endpackage

// File: rtl/rlm_hold.sv
`timescale 1ns/1ps
// Holds the last DEPTH accepted samples; index DEPTH-1 is the oldest.
module rlm_hold
  import rlm_pkg::*;
#(
  parameter int DEPTH = HOLD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  smp_t             din,
  output smp_t             held [DEPTH],
  output logic [DEPTH-1:0] held_v
);
  smp_t             d_q [DEPTH];
  logic [DEPTH-1:0] v_q;
  logic [DEPTH-1:0] v_d;

  always_comb begin
    v_d = v_q;
    if (en) v_d = {v_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= v_d;
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (en) d_q[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (en) d_q[k] <= d_q[k-1];
      end
    end
    assign held[k] = d_q[k];
  end

  assign held_v = v_q;
endmodule

// File: rtl/rlm_decide.sv
`timescale 1ns/1ps
// Column-wide run decision over the four rows of a stripe column.
module rlm_decide
  import rlm_pkg::*;
(
  input  smp_t             win [ROWS],
  output logic             run_col,
  output logic             all_zero,
  output logic [ROW_W-1:0] pos
);
  always_comb begin
    all_zero = 1'b1;
    pos      = '0;
    for (int k = ROWS - 1; k >= 0; k--) begin
      if (win[k].m_bit) begin
        all_zero = 1'b0;
        pos      = ROW_W'(k);
      end
    end
  end

  assign run_col = win[0].rl_elig;
endmodule

// File: rtl/rlm_pack.sv
`timescale 1ns/1ps
// Builds the slot bundle for one emitted sample.
module rlm_pack
  import rlm_pkg::*;
#(
  parameter int RL_CTX  = 17,
  parameter int UNI_CTX = 18
) (
  input  emit_e            mode,
  input  smp_t             cur,
  input  smp_t             hit,
  input  logic [ROW_W-1:0] pos,
  output pair_t            slot [SLOTS],
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CTX_W-1:0] RL_L  = CTX_W'(RL_CTX);
  localparam logic [CTX_W-1:0] UNI_L = CTX_W'(UNI_CTX);

  pair_t mag_p, sgn_p;

  assign mag_p = '{pass: cur.pass, ctx: cur.m_ctx, dec: cur.m_bit};
  assign sgn_p = '{pass: cur.pass, ctx: cur.s_ctx, dec: cur.s_bit};

  always_comb begin
    for (int k = 0; k < SLOTS; k++) slot[k] = '0;
    cnt = '0;
    unique case (mode)
      EMIT_PLAIN: begin
        if (cur.m_vld) begin
          slot[0] = mag_p;
          if (cur.s_vld) slot[1] = sgn_p;
        end else if (cur.s_vld) begin
          slot[0] = sgn_p;
        end
        cnt = CNT_W'(cur.m_vld) + CNT_W'(cur.s_vld);
      end
      EMIT_RUN_OK: begin
        slot[0] = '{pass: PASS_CLEAN, ctx: RL_L, dec: 1'b0};
        cnt     = CNT_W'(1);
      end
      EMIT_RUN_FAIL: begin
        slot[0] = '{pass: PASS_CLEAN, ctx: RL_L, dec: 1'b1};
        for (int k = 0; k < ROW_W; k++)
          slot[1+k] = '{pass: PASS_CLEAN, ctx: UNI_L, dec: pos[ROW_W-1-k]};
        slot[SLOTS-1] = '{pass: PASS_CLEAN, ctx: hit.s_ctx, dec: hit.s_bit};
        cnt = CNT_W'(SLOTS);
      end
      default: cnt = '0;
    endcase
  end
endmodule

// File: rtl/rlm_merge.sv
`timescale 1ns/1ps
module rlm_merge
  import rlm_pkg::*;
#(
  parameter int RL_CTX  = 17,
  parameter int UNI_CTX = 18
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [ROW_W-1:0]          in_row,
  input  logic                      in_rl_elig,
  input  logic [PASS_W-1:0]         in_pass,
  input  logic                      in_mag_vld,
  input  logic [CTX_W-1:0]          in_mag_ctx,
  input  logic                      in_mag_bit,
  input  logic                      in_sgn_vld,
  input  logic [CTX_W-1:0]          in_sgn_ctx,
  input  logic                      in_sgn_bit,
  output logic [CNT_W-1:0]          out_cnt,
  output logic [SLOTS*PASS_W-1:0]   out_pass,
  output logic [SLOTS*CTX_W-1:0]    out_ctx,
  output logic [SLOTS-1:0]          out_dec
);
  smp_t             din;
  smp_t             held [HOLD];
  logic [HOLD-1:0]  held_v;
  smp_t             win  [ROWS];
  smp_t             cur, hit;
  logic             run_col, all_zero, fire;
  logic [ROW_W-1:0] pos;
  emit_e            mode;
  logic             col_run_q, col_run_d;
  logic [ROW_W-1:0] col_lim_q, col_lim_d;
  pair_t            slot_n [SLOTS];
  pair_t            slot_q [SLOTS];
  logic [CNT_W-1:0] cnt_n, cnt_q;

  assign din = '{row: in_row, rl_elig: in_rl_elig, m_vld: in_mag_vld,
                 m_ctx: in_mag_ctx, m_bit: in_mag_bit, pass: in_pass,
                 s_vld: in_sgn_vld, s_ctx: in_sgn_ctx, s_bit: in_sgn_bit};

  rlm_hold #(.DEPTH(HOLD)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (in_valid),
    .din    (din),
    .held   (held),
    .held_v (held_v)
  );

  // Oldest held sample is row 0 of the column being decided.
  for (genvar k = 0; k < HOLD; k++) begin : g_win
    assign win[k] = held[HOLD-1-k];
  end
  assign win[ROWS-1] = din;

  rlm_decide u_decide (
    .win      (win),
    .run_col  (run_col),
    .all_zero (all_zero),
    .pos      (pos)
  );

  assign cur  = held[HOLD-1];
  assign hit  = win[pos];
  assign fire = in_valid & held_v[HOLD-1];

  always_comb begin
    mode      = EMIT_NONE;
    col_run_d = col_run_q;
    col_lim_d = col_lim_q;
    if (fire) begin
      if (cur.row == '0) begin
        if (run_col) begin
          mode      = all_zero ? EMIT_RUN_OK : EMIT_RUN_FAIL;
          col_run_d = 1'b1;
          col_lim_d = all_zero ? ROW_W'(ROWS - 1) : pos;
        end else begin
          mode      = EMIT_PLAIN;
          col_run_d = 1'b0;
        end
      end else if (!(col_run_q && (cur.row <= col_lim_q))) begin
        mode = EMIT_PLAIN;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_run_q <= 1'b0;
      col_lim_q <= '0;
    end else if (fire) begin
      col_run_q <= col_run_d;
      col_lim_q <= col_lim_d;
    end
  end

  rlm_pack #(.RL_CTX(RL_CTX), .UNI_CTX(UNI_CTX)) u_pack (
    .mode (mode),
    .cur  (cur),
    .hit  (hit),
    .pos  (pos),
    .slot (slot_n),
    .cnt  (cnt_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int k = 0; k < SLOTS; k++) slot_q[k] <= '0;
    end else begin
      cnt_q <= cnt_n;
      for (int k = 0; k < SLOTS; k++) slot_q[k] <= slot_n[k];
    end
  end

  assign out_cnt = cnt_q;
  for (genvar k = 0; k < SLOTS; k++) begin : g_flat
    assign out_pass[k*PASS_W +: PASS_W] = slot_q[k].pass;
    assign out_ctx[k*CTX_W +: CTX_W]    = slot_q[k].ctx;
    assign out_dec[k]                   = slot_q[k].dec;
  end
endmodule

// File: rtl/rlm_merge_chk.sv
`timescale 1ns/1ps
module rlm_merge_chk
  import rlm_pkg::*;
#(
  parameter int RL_CTX  = 17,
  parameter int UNI_CTX = 18
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [CNT_W-1:0]        out_cnt,
  input logic [SLOTS*PASS_W-1:0] out_pass,
  input logic [SLOTS*CTX_W-1:0]  out_ctx,
  input logic [SLOTS-1:0]        out_dec
);
  assert_cnt_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt <= CNT_W'(SLOTS));

  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> (out_cnt == '0));

  for (genvar k = 0; k < SLOTS; k++) begin : g_idle
    assert_idle_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_cnt <= CNT_W'(k)) |->
        (out_ctx[k*CTX_W +: CTX_W] == '0 && out_pass[k*PASS_W +: PASS_W] == '0
         && !out_dec[k]));
  end

  assert_run_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cnt == CNT_W'(1) && out_ctx[CTX_W-1:0] == CTX_W'(RL_CTX)) |->
      (!out_dec[0] && out_pass[PASS_W-1:0] == PASS_CLEAN));

  assert_run_fail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cnt == CNT_W'(SLOTS)) |->
      (out_ctx[CTX_W-1:0] == CTX_W'(RL_CTX) && out_dec[0]
       && out_ctx[CTX_W +: CTX_W] == CTX_W'(UNI_CTX)
       && out_ctx[(SLOTS-2)*CTX_W +: CTX_W] == CTX_W'(UNI_CTX)
       && out_pass == {SLOTS{PASS_CLEAN}}));
endmodule

bind rlm_merge rlm_merge_chk #(.RL_CTX(RL_CTX), .UNI_CTX(UNI_CTX)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .out_cnt  (out_cnt),
  .out_pass (out_pass),
  .out_ctx  (out_ctx),
  .out_dec  (out_dec)
);

// File: tb/tb_rlm_merge.sv
`timescale 1ns/1ps
module tb_rlm_merge;
  typedef struct {
    int row; bit rl; bit mv; int mctx; bit mb; int pass; bit sv; int sctx; bit sb;
  } tsmp_t;
  typedef struct {
    int n; int pass[4]; int ctx[4]; int dec[4]; int req;
  } tgrp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_row = '0;
  logic        in_rl_elig = 1'b0;
  logic [1:0]  in_pass = '0;
  logic        in_mag_vld = 1'b0;
  logic [4:0]  in_mag_ctx = '0;
  logic        in_mag_bit = 1'b0;
  logic        in_sgn_vld = 1'b0;
  logic [4:0]  in_sgn_ctx = '0;
  logic        in_sgn_bit = 1'b0;
  logic [2:0]  out_cnt;
  logic [7:0]  out_pass;
  logic [19:0] out_ctx;
  logic [3:0]  out_dec;

  int checks = 0;
  int bad = 0;
  bit ended = 0;
  tsmp_t hist[$];
  tgrp_t expq[$];

  always #5 clk = ~clk;

  rlm_merge dut (.*);

  function automatic tsmp_t mk(int row, bit rl, bit mv, int mctx, bit mb,
                               int pass, bit sv, int sctx, bit sb);
    tsmp_t s;
    s.row = row; s.rl = rl; s.mv = mv; s.mctx = mctx; s.mb = mb;
    s.pass = pass; s.sv = sv; s.sctx = sctx; s.sb = sb;
    return s;
  endfunction

  function automatic void add(ref tgrp_t g, input int p, input int c, input int d);
    g.pass[g.n] = p; g.ctx[g.n] = c; g.dec[g.n] = d; g.n++;
  endfunction

  function automatic tgrp_t empty_grp(int req);
    tgrp_t g;
    g.n = 0; g.req = req;
    for (int k = 0; k < 4; k++) begin g.pass[k] = 0; g.ctx[k] = 0; g.dec[k] = 0; end
    return g;
  endfunction

  // Expected pairs for history entry m, from the requirements.
  function automatic tgrp_t expect_for(int m);
    tgrp_t g;
    int cs, p, r;
    r  = hist[m].row;
    cs = m - r;
    g  = empty_grp(3);
    if (hist[cs].rl) begin            // R8: only row 0 flag counts
      p = -1;
      for (int k = 0; k < 4; k++) if (hist[cs+k].mb && p < 0) p = k;
      if (r == 0) begin
        if (p < 0) begin              // R4: all-zero run
          g.req = 4; add(g, 3, 17, 0);
        end else begin                // R5: interrupted run
          g.req = 5;
          add(g, 3, 17, 1); add(g, 3, 18, (p >> 1) & 1); add(g, 3, 18, p & 1);
          add(g, 3, hist[cs+p].sctx, hist[cs+p].sb);
        end
        return g;
      end
      g.req = (p < 0) ? 4 : 6;        // R6: rows up to p are silent
      if (p < 0 || r <= p) return g;
    end
    if (hist[m].mv) add(g, hist[m].pass, hist[m].mctx, hist[m].mb);   // R3
    if (hist[m].sv) add(g, hist[m].pass, hist[m].sctx, hist[m].sb);
    return g;
  endfunction

  task automatic send(tsmp_t s);
    @(negedge clk); #1;
    in_valid = 1'b1; in_row = 2'(s.row); in_rl_elig = s.rl; in_pass = 2'(s.pass);
    in_mag_vld = s.mv; in_mag_ctx = 5'(s.mctx); in_mag_bit = s.mb;
    in_sgn_vld = s.sv; in_sgn_ctx = 5'(s.sctx); in_sgn_bit = s.sb;
    hist.push_back(s);
    if (hist.size() >= 4) expq.push_back(expect_for(hist.size() - 4));
    else expq.push_back(empty_grp(2));
  endtask

  task automatic idle();
    @(negedge clk); #1;
    in_valid = 1'b0;
    expq.push_back(empty_grp(2));     // R2: no valid input, nothing out
  endtask

  task automatic send_col(tsmp_t c0, tsmp_t c1, tsmp_t c2, tsmp_t c3);
    send(c0); send(c1); send(c2); send(c3);
  endtask

  // Monitor: one expected group per clock edge, compared away from the edge.
  always @(negedge clk) begin
    if (expq.size() > 0) begin
      tgrp_t g;
      logic [7:0]  ep;
      logic [19:0] ec;
      logic [3:0]  ed;
      g = expq.pop_front();
      ep = '0; ec = '0; ed = '0;      // R7: unused slots read zero
      for (int k = 0; k < g.n; k++) begin
        ep[k*2 +: 2] = 2'(g.pass[k]); ec[k*5 +: 5] = 5'(g.ctx[k]); ed[k] = 1'(g.dec[k]);
      end
      checks++;
      if (out_cnt !== 3'(g.n) || out_pass !== ep || out_ctx !== ec || out_dec !== ed) begin
        bad++;
        $display("FAIL R%0d: got cnt=%0d pass=%h ctx=%h dec=%h exp cnt=%0d pass=%h ctx=%h dec=%h",
                 g.req, out_cnt, out_pass, out_ctx, out_dec, g.n, ep, ec, ed);
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog: got no end, exp end before limit");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (out_cnt !== 0 || out_pass !== 0 || out_ctx !== 0 || out_dec !== 0) begin
      bad++; $display("FAIL R1: got cnt=%0d ctx=%h exp cnt=0 ctx=0", out_cnt, out_ctx);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_cnt !== 0 || out_ctx !== 0) begin
      bad++; $display("FAIL R1: got cnt=%0d ctx=%h exp cnt=0 ctx=0 after release", out_cnt, out_ctx);
    end

    // R3: plain columns with mixed pair presence and passes
    send_col(mk(0,0,1,3,1,1,1,9,0), mk(1,0,1,5,0,2,0,0,0),
             mk(2,0,0,0,0,1,1,11,1), mk(3,0,0,0,0,2,0,0,0));
    // R4: all-zero run
    send_col(mk(0,1,1,0,0,3,0,0,0), mk(1,0,1,0,0,3,1,12,1),
             mk(2,0,1,0,0,3,0,0,0), mk(3,0,1,0,0,3,0,0,0));
    // R5/R6: interrupted run at each row
    for (int p = 0; p < 4; p++) begin
      tsmp_t c[4];
      for (int r = 0; r < 4; r++)
        c[r] = mk(r, r == 0, 1, 2 + r, r >= p && ((r - p) % 2 == 0), 3,
                  r >= p, 9 + r, r[0]);
      send_col(c[0], c[1], c[2], c[3]);
    end
    // R8: flag on a later row has no effect
    send_col(mk(0,0,1,4,0,2,0,0,0), mk(1,1,1,6,0,2,0,0,0),
             mk(2,1,1,7,1,1,1,10,1), mk(3,0,0,0,0,1,0,0,0));
    // R2: idle gaps inside a column hold the samples
    send(mk(0,1,1,0,0,3,0,0,0)); idle(); send(mk(1,0,1,0,1,3,1,13,0));
    idle(); idle(); send(mk(2,0,1,8,1,3,1,14,1)); send(mk(3,0,1,1,0,3,0,0,0));
    // mixed stream
    for (int col = 0; col < 40; col++) begin
      bit rl;
      rl = ($urandom % 3) == 0;
      for (int r = 0; r < 4; r++) begin
        tsmp_t s;
        bit mb;
        mb = ($urandom % 4) == 0;
        s = mk(r, (r == 0) ? rl : bit'($urandom % 2), bit'($urandom % 4 != 0),
               int'($urandom % 17), mb, rl ? 3 : 1 + int'($urandom % 3),
               mb && bit'($urandom % 2), int'($urandom % 17), bit'($urandom % 2));
        send(s);
        if ($urandom % 5 == 0) idle();
      end
    end
    // flush the last column out
    send_col(mk(0,0,0,0,0,1,0,0,0), mk(1,0,0,0,0,1,0,0,0),
             mk(2,0,0,0,0,1,0,0,0), mk(3,0,0,0,0,1,0,0,0));
    repeat (4) idle();
    @(negedge clk); @(negedge clk);
    finish_run();
  end
endmodule